// File: doc/BRIEF.md
# SPI Error Flag Controller

This block is the register front end and error logic of a byte-wide SPI peripheral. A CPU reaches three registers through a simple single-cycle bus: control, status and data. A separate shift engine does the serial work. It reports itself to this block through three signals: a busy level, a one-cycle done pulse and the received byte. This block turns those signals into a transfer-complete flag and into three error flags: mode fault, overrun and write collision. It applies the side effects of each error to the control bits and drives one interrupt request.

Each flag has its own clearing sequence made of bus accesses. The block tracks each sequence with a per-flag "armed" register, which a status read sets while the flag is up. A mode fault drops the peripheral out of master mode and disables it. It then refuses any control write that tries to turn those bits back on, until the fault's own clearing sequence completes. The slave-select pin is asynchronous and passes through a two-stage synchronizer before the block checks it for a fault.

Top module: `spi_errflag_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every control bit, flag, armed state and the receive byte. The register map is as follows. Address 0 is control, with enable in bit 0, master in bit 1 and interrupt-enable in bit 2. Address 1 is status, with transfer-complete in bit 0, mode fault in bit 1, overrun in bit 2 and write collision in bit 3. Address 2 is data. All unused bits read 0.
- R2: The synchronized slave-select can be low while the master bit is set. In that case, at the next edge the mode-fault flag sets and both the enable bit and the master bit clear. A low level on `ss_n` reaches the check after two register stages.
- R3: The mode-fault flag clears on a control write that comes after a status read taken while the flag was set. That write loads all control bits unmasked.
- R4: The mode-fault flag can be set without its clearing sequence being armed. A control write in that state cannot set enable or master, but it does update interrupt-enable.
- R5: A done pulse sets transfer-complete. The flag clears on a data read or a data write that comes after a status read taken while the flag was set. Extra status reads in between leave the sequence armed. A data access with no arming read first leaves the flag set.
- R6: A done pulse can arrive while transfer-complete is set and is not being cleared in the same cycle. That pulse sets overrun and discards its byte. The data register keeps the earlier byte.
- R7: Any status read clears overrun, unless a new overrun occurs in that same cycle.
- R8: A data write while `eng_busy` is high sets write collision and gives no load pulse. A data write while idle gives a one-cycle `eng_load` with `eng_tx` equal to the written byte.
- R9: Write collision clears on a data read that comes after a status read taken while the flag was set. A data write in place of that read leaves the flag set.
- R10: `irq` is high exactly when interrupt-enable is set and at least one of transfer-complete, mode fault or overrun is set. Write collision alone never raises it.
- R11: A done pulse that is not an overrun loads `eng_rx` into the receive byte, and a data read returns that byte.
- R12: A flag's set event and its clear event can fall in the same cycle. When they do, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| ss_n | input | 1 | Asynchronous slave-select pin, active low |
| eng_busy | input | 1 | Shift engine transfer in progress |
| eng_done | input | 1 | One-cycle pulse, byte finished |
| eng_rx | input | 8 | Byte received by the engine |
| eng_load | output | 1 | Start a transfer with `eng_tx` |
| eng_tx | output | 8 | Byte to transmit |
| eng_en | output | 1 | Peripheral enable, gates engine outputs |
| eng_master | output | 1 | Master mode select |
| irq | output | 1 | Interrupt request |

## Verification
The transfer-complete path is driven with four patterns, and each one separates a different fault:
- A clean status-then-data sequence.
- Two done pulses with no clear between them, which separates an overrun from a silent overwrite of the buffer.
- A repeated status read before the data access, which shows whether the arming survives.
- A data access with no arming read, which shows whether the clear is wrongly unconditional.

A done pulse is also made to land on the clearing access, to show which of set and clear takes priority. The write-collision sequence is tried once with a data write in the second step and once with a data read. A mode fault is checked twice: with control writes before its arming read, which exercises the lock, and with a control write after that read, which exercises the clear.

// File: rtl/spi_errflag_pkg.sv
package spi_errflag_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DAT = 2'd2;

  typedef struct packed {
    logic ie;
    logic mstr;
    logic en;
  } ctl_t;

  typedef struct packed {
    logic wcol;
    logic ovr;
    logic modf;
    logic done;
  } sts_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam int STS_W = $bits(sts_t);

  // set has priority over clear
  function automatic logic flag_next(logic cur, logic set_ev, logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

  // sequence arming: a status read samples the flag, a consuming access drops it
  function automatic logic arm_next(logic cur, logic flag, logic sts_rd, logic consume);
    if (sts_rd) return flag;
    if (consume) return 1'b0;
    return cur;
  endfunction

  function automatic logic irq_of(ctl_t c, sts_t s);
    return c.ie & (s.done | s.modf | s.ovr);
  endfunction

  function automatic logic [DATA_W-1:0] ctl_word(ctl_t c);
    return {{(DATA_W-CTL_W){1'b0}}, c};
  endfunction

  function automatic logic [DATA_W-1:0] sts_word(sts_t s);
    return {{(DATA_W-STS_W){1'b0}}, s};
  endfunction
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_errflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] wbits,
  input  logic             lock,
  input  logic             fault_evt,
  output ctl_t             ctl
);
  ctl_t ctl_d;
  ctl_t wr_val;

  always_comb begin
    wr_val      = ctl_t'(wbits);
    wr_val.en   = wr_val.en   & ~lock;
    wr_val.mstr = wr_val.mstr & ~lock;
    ctl_d = ctl_wr ? wr_val : ctl;
    if (fault_evt) begin
      ctl_d.en   = 1'b0;
      ctl_d.mstr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_d;
  end

  // R4
  modf_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && ctl_wr) |=> (!ctl.en && !ctl.mstr));
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_errflag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sts_rd,
  input  logic dat_rd,
  input  logic dat_wr,
  input  logic ctl_wr,
  input  logic eng_done,
  input  logic eng_busy,
  input  logic fault_evt,
  output sts_t sts,
  output logic lock,
  output logic ovr_evt,
  output logic wcol_evt
);
  logic done_arm, modf_arm, wcol_arm;
  logic done_clr, modf_clr, wcol_clr;
  logic dat_acc;
  sts_t sts_d;

  assign dat_acc  = dat_rd | dat_wr;
  assign done_clr = done_arm & dat_acc;
  assign modf_clr = modf_arm & ctl_wr;
  assign wcol_clr = wcol_arm & dat_rd;
  assign ovr_evt  = eng_done & sts.done & ~done_clr;
  assign wcol_evt = dat_wr & eng_busy;
  assign lock     = sts.modf & ~modf_arm;

  always_comb begin
    sts_d.done = flag_next(sts.done, eng_done,  done_clr);
    sts_d.modf = flag_next(sts.modf, fault_evt, modf_clr);
    sts_d.ovr  = flag_next(sts.ovr,  ovr_evt,   sts_rd);
    sts_d.wcol = flag_next(sts.wcol, wcol_evt,  wcol_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts      <= '0;
      done_arm <= 1'b0;
      modf_arm <= 1'b0;
      wcol_arm <= 1'b0;
    end else begin
      sts      <= sts_d;
      done_arm <= arm_next(done_arm, sts.done, sts_rd, dat_acc);
      modf_arm <= arm_next(modf_arm, sts.modf, sts_rd, ctl_wr);
      wcol_arm <= arm_next(wcol_arm, sts.wcol, sts_rd, dat_rd);
    end
  end

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !ovr_evt) |=> !sts.ovr);
  // R9
  wcol_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts.wcol && dat_wr) |=> sts.wcol);
  // R12
  done_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> sts.done);
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold
  import spi_errflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_done,
  input  logic              ovr_evt,
  input  logic [DATA_W-1:0] rx_in,
  output logic [DATA_W-1:0] rx_buf
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    rx_buf <= '0;
    else if (eng_done && !ovr_evt) rx_buf <= rx_in;
  end

  // R6
  ovr_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(rx_buf));
endmodule

// File: rtl/spi_errflag_ctrl.sv
module spi_errflag_ctrl
  import spi_errflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ss_n,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rx,
  output logic              eng_load,
  output logic [DATA_W-1:0] eng_tx,
  output logic              eng_en,
  output logic              eng_master,
  output logic              irq
);
  logic ctl_wr, sts_rd, dat_rd, dat_wr;
  logic ss_sync_n, fault_evt, lock, ovr_evt, wcol_evt;
  ctl_t ctl;
  sts_t sts;
  logic [DATA_W-1:0] rx_buf;

  assign ctl_wr = bus_sel &  bus_wr & (bus_addr == ADDR_CTL);
  assign sts_rd = bus_sel & ~bus_wr & (bus_addr == ADDR_STS);
  assign dat_rd = bus_sel & ~bus_wr & (bus_addr == ADDR_DAT);
  assign dat_wr = bus_sel &  bus_wr & (bus_addr == ADDR_DAT);

  spi_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ss_n), .sync_n(ss_sync_n)
  );

  assign fault_evt = ctl.mstr & ~ss_sync_n;

  spi_ctrl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wbits(bus_wdata[CTL_W-1:0]),
    .lock(lock), .fault_evt(fault_evt), .ctl(ctl)
  );

  spi_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .sts_rd(sts_rd), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .ctl_wr(ctl_wr), .eng_done(eng_done), .eng_busy(eng_busy),
    .fault_evt(fault_evt), .sts(sts), .lock(lock), .ovr_evt(ovr_evt),
    .wcol_evt(wcol_evt)
  );

  spi_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .eng_done(eng_done), .ovr_evt(ovr_evt),
    .rx_in(eng_rx), .rx_buf(rx_buf)
  );

  assign eng_load   = dat_wr & ~eng_busy;
  assign eng_tx     = bus_wdata;
  assign eng_en     = ctl.en;
  assign eng_master = ctl.mstr;
  assign irq        = irq_of(ctl, sts);

  always_comb begin
    case (bus_addr)
      ADDR_CTL: bus_rdata = ctl_word(ctl);
      ADDR_STS: bus_rdata = sts_word(sts);
      ADDR_DAT: bus_rdata = rx_buf;
      default:  bus_rdata = '0;
    endcase
  end

  // R2
  modf_forces_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts.modf) |-> (!ctl.en && !ctl.mstr));
  // R10
  irq_wcol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts.done && !sts.modf && !sts.ovr) |-> !irq);
  // R8
  wcol_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> sts.wcol);
endmodule

// File: tb/spi_errflag_ctrl_tb.sv
module spi_errflag_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, eng_rx = 0, eng_tx;
  logic ss_n = 1, eng_busy = 0, eng_done = 0;
  logic eng_load, eng_en, eng_master, irq;

  int n_chk = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";

  spi_errflag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_n(ss_n), .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx),
    .eng_load(eng_load), .eng_tx(eng_tx), .eng_en(eng_en),
    .eng_master(eng_master), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  int m_en, m_ms, m_ie, m_done, m_modf, m_ovr, m_wcol;
  int m_darm, m_marm, m_warm, m_buf;
  int ssq[$];
  bit m_live = 0;

  always @(posedge clk) begin
    int sr, dr, dw, cw, fault, dclr, ovr_ev, wc_ev, locked;
    int n_done, n_modf, n_ovr, n_wcol, n_darm, n_marm, n_warm;
    if (!rst_n) begin
      m_en = 0; m_ms = 0; m_ie = 0; m_done = 0; m_modf = 0; m_ovr = 0; m_wcol = 0;
      m_darm = 0; m_marm = 0; m_warm = 0; m_buf = 0;
      ssq = {1, 1};
      m_live = 1;
    end else if (m_live) begin
      sr = (bus_sel && !bus_wr && bus_addr == 1);
      dr = (bus_sel && !bus_wr && bus_addr == 2);
      dw = (bus_sel &&  bus_wr && bus_addr == 2);
      cw = (bus_sel &&  bus_wr && bus_addr == 0);
      fault  = m_ms && (ssq[0] == 0);
      dclr   = m_darm && (dr || dw);
      ovr_ev = eng_done && m_done && !dclr;
      wc_ev  = dw && eng_busy;
      n_done = eng_done ? 1 : (dclr ? 0 : m_done);
      n_ovr  = ovr_ev ? 1 : (sr ? 0 : m_ovr);
      n_wcol = wc_ev ? 1 : ((m_warm && dr) ? 0 : m_wcol);
      n_modf = fault ? 1 : ((m_marm && cw) ? 0 : m_modf);
      n_darm = sr ? m_done : ((dr || dw) ? 0 : m_darm);
      n_warm = sr ? m_wcol : (dr ? 0 : m_warm);
      n_marm = sr ? m_modf : (cw ? 0 : m_marm);
      if (eng_done && !ovr_ev) m_buf = eng_rx;
      locked = m_modf && !m_marm;
      if (cw) begin
        m_ie = bus_wdata[2];
        m_en = bus_wdata[0] && !locked;
        m_ms = bus_wdata[1] && !locked;
      end
      if (fault) begin m_en = 0; m_ms = 0; end
      m_done = n_done; m_ovr = n_ovr; m_wcol = n_wcol; m_modf = n_modf;
      m_darm = n_darm; m_warm = n_warm; m_marm = n_marm;
      void'(ssq.pop_front());
      ssq.push_back(int'(ss_n));
    end
  end

  function automatic int m_rd(input int a);
    case (a)
      0: return m_ie * 4 + m_ms * 2 + m_en;
      1: return m_wcol * 8 + m_ovr * 4 + m_modf * 2 + m_done;
      2: return m_buf;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_live && rst_n) begin
      int exp_irq;
      exp_irq = m_ie && (m_done || m_modf || m_ovr);
      chk("R10 irq", int'(irq), exp_irq);
      chk("R2 eng_en", int'(eng_en), m_en);
      chk("R2 eng_master", int'(eng_master), m_ms);
      chk("R8 eng_load", int'(eng_load), int'(bus_sel && bus_wr && bus_addr == 2 && !eng_busy));
      chk({cur_req, " rdata"}, int'(bus_rdata), m_rd(int'(bus_addr)));
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
      summary();
    end
  end

  task automatic step(input bit sel, input bit wr, input int a, input int wd,
                      input bit busy, input bit done, input int rx);
    @(negedge clk); #1;
    bus_sel = sel; bus_wr = wr; bus_addr = 2'(a); bus_wdata = 8'(wd);
    eng_busy = busy; eng_done = done; eng_rx = 8'(rx);
    #1;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(input int a, input int exp, input string req);
    step(1, 0, a, 0, 0, 0, 0);
    chk(req, int'(bus_rdata), exp);
  endtask
  task automatic wr(input int a, input int d); step(1, 1, a, d, 0, 0, 0); endtask
  task automatic pulse(input int rx); step(0, 0, 0, 0, 0, 1, rx); endtask

  initial begin
    rst_n = 0;
    repeat (3) idle();
    rst_n = 1;
    cur_req = "R1";
    rd(0, 0, "R1 ctl reset"); rd(1, 0, "R1 sts reset"); rd(2, 0, "R1 dat reset");
    chk("R1 irq reset", int'(irq), 0);

    wr(0, 8'h07);
    rd(0, 8'h07, "R1 ctl layout");
    cur_req = "R8";
    wr(2, 8'h3C);
    chk("R8 load idle", int'(eng_load), 1);
    chk("R8 tx byte", int'(eng_tx), 8'h3C);

    cur_req = "R5";
    pulse(8'hA5); idle();
    rd(1, 8'h01, "R5 done set");
    chk("R10 irq on done", int'(irq), 1);
    rd(2, 8'hA5, "R11 rx byte");
    rd(1, 8'h00, "R5 done cleared");

    cur_req = "R6";
    pulse(8'h11); pulse(8'h22); idle();
    rd(1, 8'h05, "R6 overrun set");
    rd(1, 8'h01, "R7 ovr cleared by status read");
    rd(2, 8'h11, "R6 earlier byte kept");
    rd(1, 8'h00, "R5 done cleared after ovr");

    cur_req = "R5";
    pulse(8'h33); idle();
    rd(1, 8'h01, "R5 arm");
    idle();
    rd(1, 8'h01, "R5 re-arm");
    rd(2, 8'h33, "R11 rx byte 2");
    rd(1, 8'h00, "R5 cleared after re-arm");
    pulse(8'h44); idle();
    rd(2, 8'h44, "R5 unarmed data read");
    rd(1, 8'h01, "R5 unarmed access keeps flag");
    rd(2, 8'h44, "R5 clear");
    rd(1, 8'h00, "R5 cleared");

    cur_req = "R9";
    step(1, 1, 2, 8'h99, 1, 0, 0);
    chk("R8 no load when busy", int'(eng_load), 0);
    idle();
    rd(1, 8'h08, "R8 wcol set");
    chk("R10 wcol alone no irq", int'(irq), 0);
    wr(2, 8'h55);
    rd(1, 8'h08, "R9 data write keeps wcol");
    rd(2, 8'h44, "R9 data read clears");
    rd(1, 8'h00, "R9 wcol cleared");

    cur_req = "R12";
    pulse(8'h66); idle();
    rd(1, 8'h01, "R12 arm");
    step(1, 0, 2, 0, 0, 1, 8'h77);
    idle();
    rd(1, 8'h01, "R12 set wins over clear");
    rd(2, 8'h77, "R12 byte loaded, no overrun");
    rd(1, 8'h00, "R12 cleared");

    cur_req = "R2";
    ss_n = 0;
    repeat (4) idle();
    rd(0, 8'h04, "R2 en and master dropped");
    chk("R2 eng_en low", int'(eng_en), 0);
    chk("R10 irq on modf", int'(irq), 1);
    cur_req = "R4";
    wr(0, 8'h03);
    rd(0, 8'h00, "R4 en/master blocked, ie written");
    wr(0, 8'h07);
    rd(0, 8'h04, "R4 blocked again");
    ss_n = 1;
    repeat (3) idle();
    cur_req = "R3";
    rd(1, 8'h02, "R2 modf flag");
    wr(0, 8'h07);
    rd(1, 8'h00, "R3 modf cleared");
    rd(0, 8'h07, "R3 control restored");

    cur_req = "R1";
    rst_n = 0; idle(); idle();
    rst_n = 1;
    rd(0, 0, "R1 ctl after reset"); rd(1, 0, "R1 sts after reset");
    idle();
    summary();
  end
endmodule